// File: doc/BRIEF.md
# Toggle-Driven Aligned PWM Generator

This block drives one PWM pin from a counter that runs at a prescaled clock and from two compare points. The pin never follows a level comparison. It flips when the counter meets the duty compare point and flips again when the counter wraps at the period compare point. Left alignment puts the high phase at the start of each period. Right alignment puts it at the end. Right alignment is obtained from the level the pin holds when a period starts and from a compare point placed at the period minus the duty.

Configuration needs four inputs: an alignment, a requested PWM frequency in hertz and a resolution in counter steps, followed by a start pulse. The block searches a table of power-of-two clock dividers for the first one whose divided clock lies strictly inside a ±1% band around the frequency times the resolution. It then reports the PWM frequency it actually achieved, or zero if no divider fits. A duty write is held until the current period ends, so every period is complete and free of glitches. Duty values of 0 and of the resolution or more stop compare toggling and park the pin at a constant level. A power-enable input stops the block and keeps the last duty setting.

Top module: `tgl_pwm_top`

## Requirements
- R1: While and right after reset, `pwm_o` is 0, `duty_rdy` is 1 and `cfg_ok` is 0.
- R2: After `cfg_start`, the block tries divider exponents s = 0, 1, ..., 9 in that order. D = CORE_HZ >> s is the divided clock. With t = freq*res and w = floor(t/100), the first s that satisfies t-w < D < t+w is selected. `cfg_done` then pulses with `cfg_ok`=1 and `cfg_hz` = floor(D/res). Each counter step lasts 2^s clocks.
- R3: If no exponent qualifies, `cfg_done` pulses with `cfg_ok`=0 and `cfg_hz`=0, and `pwm_o` stays 0.
- R4: Left alignment (`cfg_align`=0), duty d with 0<d<res: at counter value c (0..res-1), `pwm_o` is 1 exactly when c < d.
- R5: Right alignment (`cfg_align`=1), duty d with 0<d<res: `pwm_o` is 1 exactly when c >= res-d.
- R6: In both alignments, duty 0 holds `pwm_o` at 0 for the whole period, and duty >= res holds it at 1.
- R7: A write (`duty_wr` while `duty_rdy`=1) drops `duty_rdy` on the next clock. `duty_rdy` returns to 1 when the write is applied at the end of the running period. The first clock with `duty_rdy`=1 again is counter value 0 of the new setting. Writes made while `duty_rdy`=0 are ignored.
- R8: A successful configuration resets the duty to 0, so `pwm_o` stays 0 until a duty is written.
- R9: With `pwr_en`=0, `pwm_o` is 0 from the next clock and the counter is stopped. Writes are then applied to the retained duty on the following clock without touching the pin. When `pwr_en` rises, a new period starts at counter value 0 with the retained duty.
- R10: While running, the counter stays below `res` and wraps from res-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Starts a configuration search |
| cfg_align | input | 1 | 0 = left aligned, 1 = right aligned |
| cfg_freq | input | 24 | Requested PWM frequency in Hz |
| cfg_res | input | 16 | Resolution: counter steps per period |
| cfg_done | output | 1 | One-clock pulse at the end of configuration |
| cfg_ok | output | 1 | A divider was found and the block may run |
| cfg_hz | output | 32 | Achieved PWM frequency, 0 on failure |
| pwr_en | input | 1 | Run enable; 0 stops the block and parks the pin low |
| duty_wr | input | 1 | Duty write strobe |
| duty_val | input | 16 | Duty in counter steps |
| duty_rdy | output | 1 | A new duty write can be accepted |
| pwm_o | output | 1 | PWM pin |

## Verification
The pin level is the accumulated result of single toggles, so one lost or extra flip inverts the pin for the rest of the run. The error does not clear at the next period. A mismatch between the counter and the compare state therefore shows within the first period after the fault. It shows either as an inverted duty or as a period that starts at the wrong level. A wrong divider choice changes the step length by a factor of two and the reported frequency at once. A stuck pending write keeps `duty_rdy` low beyond one period.

// File: rtl/tgl_pwm_pkg.sv
package tgl_pwm_pkg;

    parameter int PWM_CNT_W  = 16;
    parameter int PWM_FREQ_W = 24;
    parameter int PWM_HZ_W   = 32;
    parameter int PWM_PS_MAX = 9;
    parameter int PWM_PS_W   = $clog2(PWM_PS_MAX + 1);
    parameter int PWM_PROD_W = PWM_FREQ_W + PWM_CNT_W;

    typedef enum logic {
        ALIGN_LEFT  = 1'b0,
        ALIGN_RIGHT = 1'b1
    } align_e;

    typedef enum logic [1:0] {
        DC_ZERO = 2'd0,
        DC_PART = 2'd1,
        DC_FULL = 2'd2
    } dcls_e;

    typedef struct packed {
        align_e                align;
        logic [PWM_PS_W-1:0]   ps;
        logic [PWM_CNT_W-1:0]  res;
    } pwm_cfg_t;

    function automatic dcls_e duty_class(input logic [PWM_CNT_W-1:0] d,
                                         input logic [PWM_CNT_W-1:0] r);
        if (d == '0)
            return DC_ZERO;
        else if (d >= r)
            return DC_FULL;
        else
            return DC_PART;
    endfunction

    function automatic logic [PWM_CNT_W-1:0] duty_cmp(input align_e a,
                                                     input logic [PWM_CNT_W-1:0] d,
                                                     input logic [PWM_CNT_W-1:0] r);
        case (duty_class(d, r))
            DC_ZERO: return '0;
            DC_FULL: return r;
            default: return (a == ALIGN_LEFT) ? d : (r - d);
        endcase
    endfunction

    // Level the pin holds at counter value 0 for a given alignment and class.
    function automatic logic start_level(input align_e a, input dcls_e c);
        return (c == DC_FULL) || (a == ALIGN_LEFT && c == DC_PART);
    endfunction

endpackage

// File: rtl/tgl_pwm_div.sv
module tgl_pwm_div #(
    parameter int N_W = 32,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           done,
    output logic [N_W-1:0] quo
);
    localparam int C_W = $clog2(N_W + 1);

    logic [D_W-1:0] rem_q;
    logic [N_W-1:0] quo_q;
    logic [C_W-1:0] cnt_q;
    logic           busy_q;
    logic           done_q;
    logic [D_W:0]   shl;
    logic           ge;
    logic [D_W-1:0] rem_n;

    always_comb begin
        shl   = {rem_q, quo_q[N_W-1]};
        ge    = shl >= {1'b0, den};
        rem_n = ge ? D_W'(shl - {1'b0, den}) : D_W'(shl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= num;
                cnt_q  <= C_W'(N_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_n;
                quo_q <= {quo_q[N_W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == C_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
endmodule

// File: rtl/tgl_pwm_cfg.sv
module tgl_pwm_cfg
    import tgl_pwm_pkg::*;
#(
    parameter int unsigned CORE_HZ = 16_000_000,
    parameter int unsigned TOL_PCT = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  align,
    input  logic [PWM_FREQ_W-1:0] freq,
    input  logic [PWM_CNT_W-1:0]  res,
    output logic                  done,
    output logic                  ok,
    output logic [PWM_HZ_W-1:0]   hz,
    output pwm_cfg_t              cfg
);
    localparam int W = PWM_PROD_W + 1;

    typedef enum logic [1:0] { CS_IDLE, CS_SRCH, CS_DIVD } cst_e;

    cst_e                  st_q;
    logic [PWM_FREQ_W-1:0] f_q;
    logic [PWM_CNT_W-1:0]  r_q;
    align_e                a_q;
    logic [PWM_PS_W-1:0]   ps_q;
    logic                  done_q, ok_q;
    logic [PWM_HZ_W-1:0]   hz_q;
    pwm_cfg_t              cfg_q;

    logic [W-1:0]          tgt, tol, dclk;
    logic [PWM_HZ_W-1:0]   dclk_hz;
    logic                  hit;
    logic                  div_start, div_done;
    logic [PWM_HZ_W-1:0]   div_quo;

    always_comb begin
        tgt       = W'(f_q) * W'(r_q);
        tol       = (tgt / W'(100)) * W'(TOL_PCT);
        dclk_hz   = PWM_HZ_W'(CORE_HZ) >> ps_q;
        dclk      = W'(dclk_hz);
        hit       = (dclk > (tgt - tol)) && (dclk < (tgt + tol));
        div_start = (st_q == CS_SRCH) && hit;
    end

    tgl_pwm_div #(.N_W(PWM_HZ_W), .D_W(PWM_CNT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (dclk_hz),
        .den   (r_q),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CS_IDLE;
            f_q    <= '0;
            r_q    <= '0;
            a_q    <= ALIGN_LEFT;
            ps_q   <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            hz_q   <= '0;
            cfg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                CS_IDLE: begin
                    if (start) begin
                        f_q  <= freq;
                        r_q  <= res;
                        a_q  <= align_e'(align);
                        ps_q <= '0;
                        ok_q <= 1'b0;
                        hz_q <= '0;
                        st_q <= CS_SRCH;
                    end
                end
                CS_SRCH: begin
                    if (hit) begin
                        st_q <= CS_DIVD;
                    end else if (ps_q == PWM_PS_W'(PWM_PS_MAX)) begin
                        done_q <= 1'b1;
                        st_q   <= CS_IDLE;
                    end else begin
                        ps_q <= ps_q + 1'b1;
                    end
                end
                default: begin
                    if (div_done) begin
                        done_q    <= 1'b1;
                        ok_q      <= 1'b1;
                        hz_q      <= div_quo;
                        cfg_q.align <= a_q;
                        cfg_q.ps  <= ps_q;
                        cfg_q.res <= r_q;
                        st_q      <= CS_IDLE;
                    end
                end
            endcase
        end
    end

    assign done = done_q;
    assign ok   = ok_q;
    assign hz   = hz_q;
    assign cfg  = cfg_q;
endmodule

// File: rtl/tgl_pwm_tick.sv
module tgl_pwm_tick
    import tgl_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [PWM_PS_W-1:0] ps,
    output logic                tick
);
    logic [PWM_PS_MAX-1:0] div_q;
    logic [PWM_PS_MAX-1:0] mask;

    always_comb begin
        mask = ~({PWM_PS_MAX{1'b1}} << ps);
        tick = (div_q & mask) == mask;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tgl_pwm_core.sv
module tgl_pwm_core
    import tgl_pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init,
    input  logic                 run,
    input  logic                 tick,
    input  pwm_cfg_t             cfg,
    input  logic                 duty_wr,
    input  logic [PWM_CNT_W-1:0] duty_val,
    output logic                 duty_rdy,
    output logic                 pin,
    output logic                 run_q,
    output logic                 restart,
    output logic [PWM_CNT_W-1:0] cnt,
    output logic [PWM_CNT_W-1:0] cmp,
    output dcls_e                cls
);
    logic [PWM_CNT_W-1:0] cnt_q, cmp_q, pend_val_q;
    dcls_e                cls_q;
    logic                 pend_q, pin_q, run_q_r;

    dcls_e                new_cls;
    logic [PWM_CNT_W-1:0] new_cmp;
    logic                 wrap, hit, tgl, fix;

    always_comb begin
        new_cls = duty_class(pend_val_q, cfg.res);
        new_cmp = duty_cmp(cfg.align, pend_val_q, cfg.res);
        wrap    = run_q_r && run && tick && (cnt_q == cfg.res - 1'b1);
        hit     = run_q_r && run && tick && (cls_q == DC_PART)
                  && ((cnt_q + 1'b1) == cmp_q);
        tgl     = hit || (wrap && cls_q == DC_PART);
        fix     = wrap && pend_q
                  && (start_level(cfg.align, cls_q) != start_level(cfg.align, new_cls));
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cnt_q      <= '0;
            cmp_q      <= '0;
            cls_q      <= DC_ZERO;
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            pin_q      <= 1'b0;
            run_q_r    <= 1'b0;
        end else begin
            run_q_r <= run;
            if (!run) begin
                cnt_q <= '0;
                pin_q <= 1'b0;
                if (pend_q) begin
                    cls_q  <= new_cls;
                    cmp_q  <= new_cmp;
                    pend_q <= 1'b0;
                end
            end else if (!run_q_r) begin
                cnt_q <= '0;
                pin_q <= start_level(cfg.align, cls_q);
            end else begin
                if (tick)
                    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
                if (wrap && pend_q) begin
                    cls_q  <= new_cls;
                    cmp_q  <= new_cmp;
                    pend_q <= 1'b0;
                end
                pin_q <= pin_q ^ tgl ^ fix;
            end
            if (duty_wr && !pend_q) begin
                pend_q     <= 1'b1;
                pend_val_q <= duty_val;
            end
        end
    end

    assign duty_rdy = !pend_q;
    assign pin      = pin_q;
    assign run_q    = run_q_r;
    assign restart  = !run || !run_q_r;
    assign cnt      = cnt_q;
    assign cmp      = cmp_q;
    assign cls      = cls_q;
endmodule

// File: rtl/tgl_pwm_top.sv
module tgl_pwm_top
    import tgl_pwm_pkg::*;
#(
    parameter int unsigned CORE_HZ = 16_000_000,
    parameter int unsigned TOL_PCT = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_start,
    input  logic                  cfg_align,
    input  logic [PWM_FREQ_W-1:0] cfg_freq,
    input  logic [PWM_CNT_W-1:0]  cfg_res,
    output logic                  cfg_done,
    output logic                  cfg_ok,
    output logic [PWM_HZ_W-1:0]   cfg_hz,
    input  logic                  pwr_en,
    input  logic                  duty_wr,
    input  logic [PWM_CNT_W-1:0]  duty_val,
    output logic                  duty_rdy,
    output logic                  pwm_o
);
    pwm_cfg_t             cfg_w;
    logic                 run_w, tick_w, restart_w, core_run_q;
    logic [PWM_CNT_W-1:0] core_cnt, core_cmp;
    dcls_e                core_cls;

    tgl_pwm_cfg #(.CORE_HZ(CORE_HZ), .TOL_PCT(TOL_PCT)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .start (cfg_start),
        .align (cfg_align),
        .freq  (cfg_freq),
        .res   (cfg_res),
        .done  (cfg_done),
        .ok    (cfg_ok),
        .hz    (cfg_hz),
        .cfg   (cfg_w)
    );

    assign run_w = pwr_en && cfg_ok;

    tgl_pwm_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart_w),
        .ps   (cfg_w.ps),
        .tick (tick_w)
    );

    tgl_pwm_core u_core (
        .clk      (clk),
        .rst      (rst),
        .init     (cfg_done),
        .run      (run_w),
        .tick     (tick_w),
        .cfg      (cfg_w),
        .duty_wr  (duty_wr),
        .duty_val (duty_val),
        .duty_rdy (duty_rdy),
        .pin      (pwm_o),
        .run_q    (core_run_q),
        .restart  (restart_w),
        .cnt      (core_cnt),
        .cmp      (core_cmp),
        .cls      (core_cls)
    );
endmodule

// File: rtl/tgl_pwm_chk.sv
module tgl_pwm_chk
    import tgl_pwm_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 run_q,
    input logic [PWM_CNT_W-1:0] cnt,
    input logic [PWM_CNT_W-1:0] cmp,
    input dcls_e                cls,
    input pwm_cfg_t             cfg,
    input logic                 pin,
    input logic                 pwr_en,
    input logic                 duty_wr,
    input logic                 duty_rdy,
    input logic                 cfg_done,
    input logic                 cfg_ok,
    input logic [PWM_HZ_W-1:0]  cfg_hz
);
    a_r4_left_level: assert property (@(posedge clk) disable iff (rst)
        (run_q && cls == DC_PART && cfg.align == ALIGN_LEFT) |-> (pin == (cnt < cmp)));

    a_r5_right_level: assert property (@(posedge clk) disable iff (rst)
        (run_q && cls == DC_PART && cfg.align == ALIGN_RIGHT) |-> (pin == (cnt >= cmp)));

    a_r6_parked: assert property (@(posedge clk) disable iff (rst)
        (run_q && cls != DC_PART) |-> (pin == (cls == DC_FULL)));

    a_r7_rdy_drop: assert property (@(posedge clk) disable iff (rst)
        (duty_wr && duty_rdy && !cfg_done) |=> !duty_rdy);

    a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !pin);

    a_r3_fail_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && !cfg_ok) |-> (cfg_hz == '0));

    a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt < cfg.res));
endmodule

bind tgl_pwm_top tgl_pwm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_q    (core_run_q),
    .cnt      (core_cnt),
    .cmp      (core_cmp),
    .cls      (core_cls),
    .cfg      (cfg_w),
    .pin      (pwm_o),
    .pwr_en   (pwr_en),
    .duty_wr  (duty_wr),
    .duty_rdy (duty_rdy),
    .cfg_done (cfg_done),
    .cfg_ok   (cfg_ok),
    .cfg_hz   (cfg_hz)
);

// File: tb/tgl_pwm_tb.sv
module tgl_pwm_top_tb_top;
    localparam longint CORE = 16_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_start = 1'b0;
    logic        cfg_align = 1'b0;
    logic [23:0] cfg_freq = '0;
    logic [15:0] cfg_res = '0;
    logic        cfg_done, cfg_ok;
    logic [31:0] cfg_hz;
    logic        pwr_en = 1'b0;
    logic        duty_wr = 1'b0;
    logic [15:0] duty_val = '0;
    logic        duty_rdy, pwm_o;

    int n_run = 0;
    int n_fail = 0;
    int cur_ps = 0;
    int cur_res = 1;
    bit cur_right = 1'b0;

    always #2 clk = ~clk;

    tgl_pwm_top dut_i (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_align(cfg_align),
        .cfg_freq(cfg_freq), .cfg_res(cfg_res), .cfg_done(cfg_done),
        .cfg_ok(cfg_ok), .cfg_hz(cfg_hz), .pwr_en(pwr_en), .duty_wr(duty_wr),
        .duty_val(duty_val), .duty_rdy(duty_rdy), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit lvl(input bit right, input int c, input int d, input int r);
        int dd = (d >= r) ? r : d;
        return right ? (c >= r - dd) : (c < dd);
    endfunction

    // Sample one full period starting at counter value 0 (current negedge).
    task automatic chk_period(input string req, input int d);
        int bad = 0;
        int first_j = -1;
        int len = cur_res * (1 << cur_ps);
        for (int j = 0; j < len; j++) begin
            if (pwm_o != lvl(cur_right, j >> cur_ps, d, cur_res)) begin
                bad++;
                if (first_j < 0) first_j = j;
            end
            if (j != len - 1) @(negedge clk);
        end
        n_run++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s duty=%0d mismatches=%0d first_at=%0d actual=%0d expected=%0d",
                     req, d, bad, first_j, bad, 0);
        end
    endtask

    task automatic do_cfg(input bit right, input int f, input int r);
        bit eok = 1'b0;
        longint ehz = 0;
        int eps = 0;
        int waitc = 0;
        longint t = longint'(f) * r;
        longint w = t / 100;
        for (int s = 0; s <= 9; s++) begin
            longint dclk = CORE >> s;
            if (!eok && dclk > t - w && dclk < t + w) begin
                eok = 1'b1; eps = s; ehz = dclk / r;
            end
        end
        @(negedge clk);
        cfg_start = 1'b1; cfg_align = right; cfg_freq = 24'(f); cfg_res = 16'(r);
        @(negedge clk);
        cfg_start = 1'b0;
        while (!cfg_done && waitc < 200) begin
            @(negedge clk); waitc++;
        end
        chk(eok ? "R2 ok" : "R3 ok", cfg_ok, eok);
        chk(eok ? "R2 hz" : "R3 hz", cfg_hz, ehz);
        if (eok) begin
            cur_ps = eps; cur_res = r; cur_right = right;
        end
        @(negedge clk);
        @(negedge clk);
        chk("R8 R3 low after cfg", pwm_o, 0);
    endtask

    task automatic set_duty(input string req, input int d, input bit check);
        int waitc = 0;
        @(negedge clk);
        duty_wr = 1'b1; duty_val = 16'(d);
        @(negedge clk);
        duty_wr = 1'b0;
        chk("R7 rdy low after write", duty_rdy, 0);
        while (!duty_rdy && waitc < 20000) begin
            @(negedge clk); waitc++;
        end
        if (check) chk_period(req, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lst[11] = '{3, 0, 5, 8, 9, 1, 7, 0, 2, 8, 4};
        int lst2[12] = '{0, 11, 4, 10, 1, 9, 0, 6, 3, 12, 2, 5};
        repeat (5) @(negedge clk);
        chk("R1 pin", pwm_o, 0);
        chk("R1 rdy", duty_rdy, 1);
        chk("R1 ok", cfg_ok, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pin after reset", pwm_o, 0);
        pwr_en = 1'b1;

        // Left, ps 0, res 8 (R4, R6, R7, R10)
        do_cfg(1'b0, 2_000_000, 8);
        for (int i = 0; i < 11; i++) set_duty("R4 R6 R10 left", lst[i], 1'b1);
        // Right, ps 0, res 8 (R5, R6)
        do_cfg(1'b1, 2_000_000, 8);
        for (int i = 0; i < 11; i++) set_duty("R5 R6 right", lst[i], 1'b1);
        // Right, ps 2, res 10
        do_cfg(1'b1, 400_000, 10);
        for (int i = 0; i < 12; i++) set_duty("R5 R6 R2 right ps2", lst2[i], 1'b1);
        // Left, ps 2, res 10
        do_cfg(1'b0, 400_000, 10);
        for (int i = 0; i < 12; i++) set_duty("R4 R6 R2 left ps2", lst2[i], 1'b1);

        // R9: power off, write while off, power back on
        set_duty("R4 before off", 6, 1'b1);
        @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk);
        begin
            int hi = 0;
            for (int k = 0; k < 60; k++) begin
                hi += pwm_o; @(negedge clk);
            end
            chk("R9 low while off", hi, 0);
        end
        set_duty("R9 write while off", 3, 1'b0);
        chk("R9 rdy returns while off", duty_rdy, 1);
        repeat (5) @(negedge clk);
        chk("R9 pin unaffected by write", pwm_o, 0);
        pwr_en = 1'b1;
        @(negedge clk);
        chk_period("R9 restart with retained duty", 3);
        @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk);
        pwr_en = 1'b1;
        @(negedge clk);
        chk_period("R9 retained across off-on", 3);

        // Prescaler search cases (R2, R3)
        do_cfg(1'b0, 62_500, 16);
        set_duty("R2 R4 ps4", 5, 1'b1);
        do_cfg(1'b1, 160_700, 100);
        do_cfg(1'b0, 1_500_000, 8);
        do_cfg(1'b0, 1_010_101, 8);
        do_cfg(1'b0, 31_250, 1);
        do_cfg(1'b1, 1_000_000, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule